// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block makes the 16x oversampling tick for a serial receiver and transmitter. It takes one clock that is already selected. A prescaler first divides that clock by 1, 2, 4 or 8. An 8-bit reload counter then counts the prescaled strobes down and produces one underflow every reload+1 strobes. Each underflow gives a one-cycle oversample tick.

A 4-bit fraction value sets how many of every 16 underflows are delayed by one extra prescaled strobe. So the average tick period is (reload+1) + fraction/16 prescaled clocks, which gives a fractional divisor. The delayed slots are spread evenly across the group of 16, not bunched together.

A count enable starts and stops the whole chain. Dropping the enable clears the prescaler, the counter and the slot position. A tick-valid output shows that at least one tick has come out since counting was last enabled.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `os_tick` and `tick_en` are both low.
- R2: The prescale ratio r is 1, 2, 4 or 8 for `div_sel` values 0, 1, 2 and 3 respectively.
- R3: With `frac` = 0, consecutive ticks are exactly r*(`reload`+1) clock cycles apart.
- R4: The cycles spanned by any 16 consecutive tick intervals total r*(16*(`reload`+1)+`frac`).
- R5: Underflow slots are numbered 0 to 15. Slot 0 is the first underflow after enabling, and the number goes up by one (mod 16) per underflow. The interval that ends at slot s is lengthened by exactly r cycles if the 4-bit bit-reversal of s is less than `frac`, and is not lengthened otherwise.
- R6: When `cnt_en` is sampled low, both outputs are low from the next cycle on, and no tick comes out while it stays low.
- R7: After `cnt_en` rises, the first tick is seen r*(1+x) cycles later, where x is 1 if slot 0 is lengthened under R5 and 0 otherwise. The slot numbering restarts at 0 on every enable.
- R8: A change of `reload` does not alter the interval already in progress. It takes effect at the next underflow.
- R9: `os_tick` is high only in cycles that follow an edge at which `cnt_en` was high. `tick_en` goes high together with the first tick and stays high until counting is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Selected count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable; low stops and clears all counting |
| div_sel | input | 2 | Prescale select: 0=/1, 1=/2, 2=/4, 3=/8 |
| reload | input | 8 | Reload value of the down counter |
| frac | input | 4 | Number of lengthened slots in each group of 16 underflows |
| os_tick | output | 1 | One-cycle oversample tick |
| tick_en | output | 1 | High once the first tick since enable has come out |

## Verification
The assertions and the reference model assume that `div_sel` and `frac` change only while `cnt_en` is low. The slot pattern and the prescale count are decided on live values, so changing them in mid-run would make per-interval lengths depend on when the change lands. The stimulus therefore drops the enable, programs the new ratio and fraction, and only then enables again. `reload`, in contrast, is changed on purpose while counting runs, one cycle after a tick, to show that the new value is picked up at the next reload.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  typedef enum logic [1:0] {
    DIV_BY_1 = 2'd0,
    DIV_BY_2 = 2'd1,
    DIV_BY_4 = 2'd2,
    DIV_BY_8 = 2'd3
  } div_sel_e;

  // Mask for a prescaler of ratio 2**sel, CW bits wide.
  function automatic logic [7:0] ratio_mask(input logic [2:0] sel);
    logic [7:0] m;
    m = '0;
    for (int i = 0; i < 8; i++) begin
      m[i] = (i < int'(sel));
    end
    return m;
  endfunction

  // Slot s is lengthened when its bit-reversed index is below the fraction.
  function automatic logic slot_lengthened(input logic [7:0] rev_slot,
                                           input logic [7:0] fraction);
    return rev_slot < fraction;
  endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             strobe
);
  import frac_baud_pkg::*;

  localparam int CW = (1 << DIV_W) - 1;

  logic [CW-1:0] pcnt;
  logic [CW-1:0] mask;
  logic [7:0]    mask_full;

  always_comb begin
    mask_full = ratio_mask(3'(sel));
    mask      = mask_full[CW-1:0];
  end

  assign strobe = run && (pcnt >= mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (!run || strobe) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + CW'(1);
    end
  end

endmodule

// File: rtl/baud_frac_seq.sv
module baud_frac_seq #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              advance,
  input  logic [FRAC_W-1:0] frac,
  output logic [FRAC_W-1:0] phase,
  output logic              stretch
);
  import frac_baud_pkg::*;

  logic [FRAC_W-1:0] rev;

  for (genvar i = 0; i < FRAC_W; i++) begin : g_rev
    assign rev[i] = phase[FRAC_W-1-i];
  end

  assign stretch = slot_lengthened(8'(rev), 8'(frac));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (!run) begin
      phase <= '0;
    end else if (advance) begin
      phase <= phase + FRAC_W'(1);
    end
  end

endmodule

// File: rtl/baud_reload_ctr.sv
module baud_reload_ctr #(
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                strobe,
  input  logic                stretch,
  input  logic [RELOAD_W-1:0] reload,
  output logic                uf
);
  logic [RELOAD_W-1:0] cnt;
  logic                dly_done;
  logic                at_zero;
  logic                hold;

  assign at_zero = (cnt == '0);
  assign hold    = stretch && !dly_done;
  assign uf      = strobe && at_zero && !hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      dly_done <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      dly_done <= 1'b0;
    end else if (strobe) begin
      if (!at_zero) begin
        cnt <= cnt - RELOAD_W'(1);
      end else if (hold) begin
        dly_done <= 1'b1;
      end else begin
        cnt      <= reload;
        dly_done <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int DIV_W    = 2,
  parameter int RELOAD_W = 8,
  parameter int FRAC_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_en,
  input  logic [DIV_W-1:0]    div_sel,
  input  logic [RELOAD_W-1:0] reload,
  input  logic [FRAC_W-1:0]   frac,
  output logic                os_tick,
  output logic                tick_en
);
  logic              pstb;
  logic              uf;
  logic              stretch;
  logic [FRAC_W-1:0] phase;

  baud_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (cnt_en),
    .sel    (div_sel),
    .strobe (pstb)
  );

  baud_frac_seq #(.FRAC_W(FRAC_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cnt_en),
    .advance (uf),
    .frac    (frac),
    .phase   (phase),
    .stretch (stretch)
  );

  baud_reload_ctr #(.RELOAD_W(RELOAD_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cnt_en),
    .strobe  (pstb),
    .stretch (stretch),
    .reload  (reload),
    .uf      (uf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      os_tick <= 1'b0;
      tick_en <= 1'b0;
    end else begin
      os_tick <= uf;
      if (!cnt_en) begin
        tick_en <= 1'b0;
      end else if (uf) begin
        tick_en <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              os_tick,
  input logic              tick_en,
  input logic              pstb,
  input logic              uf,
  input logic [FRAC_W-1:0] phase
);

  a_r9_tick_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> $past(cnt_en));

  a_r9_tick_implies_valid: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |-> tick_en);

  a_r6_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (!os_tick && !tick_en));

  a_r2_no_strobe_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |-> !pstb);

  a_r3_uf_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    uf |-> pstb);

  a_r5_phase_advances: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (phase == FRAC_W'($past(phase) + 1'b1)));

endmodule

bind frac_baud_gen frac_baud_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt_en  (cnt_en),
  .os_tick (os_tick),
  .tick_en (tick_en),
  .pstb    (pstb),
  .uf      (uf),
  .phase   (phase)
);

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [7:0] reload = 8'd0;
  logic [3:0] frac = 4'd0;
  logic       os_tick;
  logic       tick_en;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .div_sel(div_sel),
    .reload(reload), .frac(frac), .os_tick(os_tick), .tick_en(tick_en)
  );

  function automatic int lengthened(int slot, int f);
    int s;
    int rv;
    s  = slot % 16;
    rv = (s % 2) * 8 + ((s / 2) % 2) * 4 + ((s / 4) % 2) * 2 + (s / 8) % 2;
    return (rv < f) ? 1 : 0;
  endfunction

  function automatic int ratio_of(int sel);
    int r;
    r = 1;
    for (int i = 0; i < sel; i++) r = r * 2;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model, stepped at each rising edge.
  int m_pre, m_left, m_slot;
  bit m_fresh = 1, m_tick = 0, m_val = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || !cnt_en) begin
      m_tick = 0; m_val = 0; m_pre = 0; m_slot = 0; m_fresh = 1;
    end else begin
      if (m_fresh) begin
        m_left  = 1 + lengthened(0, int'(frac));
        m_fresh = 0;
      end
      m_tick = 0;
      m_pre++;
      if (m_pre == ratio_of(int'(div_sel))) begin
        m_pre = 0;
        m_left--;
        if (m_left == 0) begin
          m_tick = 1;
          m_val  = 1;
          m_slot = (m_slot + 1) % 16;
          m_left = int'(reload) + 1 + lengthened(m_slot, int'(frac));
        end
      end
    end
  end

  // Per-cycle comparison against the model (R9 and R6 outputs).
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(os_tick === m_tick, "R9 model os_tick", int'(os_tick), int'(m_tick));
      check(tick_en === m_val, "R9 model tick_en", int'(tick_en), int'(m_val));
    end
  end

  task automatic wait_tick(output int t);
    @(negedge clk);
    while (os_tick !== 1'b1) @(negedge clk);
    t = cyc;
  endtask

  // Program settings while disabled, enable, check first latency and 16 intervals.
  task automatic run16(input int sel, input int br, input int f);
    int r, t_en, t_prev, t_now, sum, iv, exp_iv;
    @(negedge clk);
    cnt_en = 1'b0;
    @(negedge clk);
    div_sel = 2'(sel); reload = 8'(br); frac = 4'(f);
    @(negedge clk);
    cnt_en = 1'b1;
    t_en = cyc;
    r = ratio_of(sel);
    wait_tick(t_prev);
    check(t_prev - t_en == r * (1 + lengthened(0, f)), "R7 first tick latency",
          t_prev - t_en, r * (1 + lengthened(0, f)));
    sum = 0;
    for (int k = 1; k <= 16; k++) begin
      wait_tick(t_now);
      iv = t_now - t_prev;
      exp_iv = r * (br + 1 + lengthened(k, f));
      if (f == 0) check(iv == exp_iv, "R3 plain interval", iv, exp_iv);
      else        check(iv == exp_iv, "R5 slot interval", iv, exp_iv);
      sum += iv;
      t_prev = t_now;
    end
    check(sum == r * (16 * (br + 1) + f), "R4 R2 sixteen-interval total",
          sum, r * (16 * (br + 1) + f));
  endtask

  initial begin
    int t0, t1, t2, t3, t_en;
    repeat (4) @(negedge clk);
    check(os_tick === 1'b0, "R1 reset os_tick", int'(os_tick), 0);
    check(tick_en === 1'b0, "R1 reset tick_en", int'(tick_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(os_tick === 1'b0 && tick_en === 1'b0, "R1 idle after reset",
          int'(os_tick) + int'(tick_en), 0);

    run16(0, 0, 0);
    run16(0, 0, 15);
    run16(0, 10, 0);
    run16(1, 10, 5);
    run16(2, 3, 8);
    run16(1, 37, 1);
    run16(3, 255, 15);
    run16(3, 2, 0);

    // R8: reload change mid-run takes effect after the running interval.
    @(negedge clk); cnt_en = 1'b0;
    @(negedge clk); div_sel = 2'd0; reload = 8'd20; frac = 4'd0;
    @(negedge clk); cnt_en = 1'b1;
    wait_tick(t0);
    reload = 8'd5;
    wait_tick(t1);
    wait_tick(t2);
    check(t1 - t0 == 21, "R8 old reload still used", t1 - t0, 21);
    check(t2 - t1 == 6, "R8 new reload applied", t2 - t1, 6);

    // R6: disable mid-run, outputs stay low.
    @(negedge clk); cnt_en = 1'b0;
    t3 = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      t3 += int'(os_tick) + int'(tick_en);
    end
    check(t3 == 0, "R6 outputs low while disabled", t3, 0);

    // R7: slot restart - run into mid-group, then re-enable with frac=1.
    @(negedge clk); reload = 8'd3; frac = 4'd1;
    @(negedge clk); cnt_en = 1'b1;
    repeat (5) wait_tick(t0);
    @(negedge clk); cnt_en = 1'b0;
    @(negedge clk); cnt_en = 1'b1;
    t_en = cyc;
    wait_tick(t1);
    check(t1 - t_en == 2, "R7 slot numbering restarts", t1 - t_en, 2);
    check(tick_en === 1'b1, "R9 valid after first tick", int'(tick_en), 1);

    @(negedge clk); cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule